// File: doc/BRIEF.md
# Two-Word Burst SRAM Core with Posted Writes

This block models a synchronous pipelined static memory with separate input and output data buses. Each access covers one location of two 18-bit words, moved as a two-word burst, lower word first. The core runs on one fabric clock in which every cycle is a half-period slot of the notional input clock. An input flag marks the slots that stand for the positive clock rise; commands are taken only in those slots. Write data arrives in the two slots that follow the next positive slot, and each word carries two active-low byte-lane selects.

A completed write is not put into the array at once. It lands in a posted-write holding register and reaches the array only when the next write completes. Reads look through the holding register and through a write that completes in the same slot, lane by lane, so every read returns the newest data. A static mode pin picks the read latency: three slots (one and a half input cycles) or two slots (one cycle). Reads may be issued in every positive slot, which keeps the output bus busy in every slot. An output-enable flag stands in for the tristate driver: it is low, and the data bus reads zero, whenever no read word is being delivered.

The write path is a five-state sequencer. WS_IDLE goes to WS_GAP on an accepted write and otherwise stays. WS_GAP always goes to WS_LO. WS_LO captures the lower word and goes to WS_HI_GAP if a new write is accepted in the same slot, or to WS_HI if not. WS_HI captures the upper word, completes the write and goes to WS_IDLE. WS_HI_GAP completes the write and goes to WS_LO for the write that follows. Reset returns the sequencer to WS_IDLE.

Top module: `ddr_burst_sram`

## Requirements
- R1: While reset is low, and in the first cycle after it, dout_oe is 0 and dout is 0. Reset clears the read pipeline, the write sequencer and the posted-write valid flag, so a write still held in the posted register is lost. The array is not cleared.
- R2: A command is accepted only in a slot with slot_pos=1. ld_n=0 with rd_wr=1 is a read, ld_n=0 with rd_wr=0 is a write, and ld_n=1 is a deselect. Commands presented while slot_pos=0 have no effect.
- R3: A location is 36 bits. Burst word 0 is bits 17:0 and word 1 is bits 35:18. For a write accepted in slot t, din and bsel_n are sampled in slot t+2 for word 0 and in slot t+3 for word 1.
- R4: With lat_full=1, a read accepted in slot t puts word 0 on dout in slot t+3 and word 1 in slot t+4, each with dout_oe=1.
- R5: With lat_full=0, a read accepted in slot t puts word 0 on dout in slot t+2 and word 1 in slot t+3, each with dout_oe=1.
- R6: Reads accepted in consecutive positive slots produce output words in consecutive slots, with no slot in which dout_oe drops.
- R7: bsel_n[0] guards bits 8:0 and bsel_n[1] guards bits 17:9 of the word sampled with it. A lane whose select is 1 keeps its stored value.
- R8: Once every accepted read has delivered its two words, dout_oe is 0 and dout is 0 in the following slot and stays so until the next read delivers.
- R9: A read returns the newest write to its address, including a write still in the posted register and a write whose upper word is sampled in the slot after the read command. Once set, the posted-write valid flag stays set until reset.
- R10: din and bsel_n outside the two data slots of an accepted write do not change any stored location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, one cycle per half-period slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_pos | input | 1 | 1 in a slot that stands for the positive input clock rise; alternates every cycle |
| lat_full | input | 1 | Read latency mode: 1 gives three slots, 0 gives two; held static outside reset |
| ld_n | input | 1 | Active-low command strobe |
| rd_wr | input | 1 | Command direction: 1 read, 0 write |
| addr | input | ADDR_W | Location address, sampled with the command |
| din | input | WORD_W | Write data word |
| bsel_n | input | BYTE_LANES | Active-low byte-lane selects for the current write word |
| dout | output | WORD_W | Read data word, zero when not enabled |
| dout_oe | output | 1 | High while dout carries a read word (output drive enable) |

## Verification
The bench builds the core with a five-bit address and the default 18-bit word split into two 9-bit lanes. The small address space lets the sequence write the same location back to back, so a posted write is retired while a new one lands on the same address. It also lets reads hit, in the very next slot, a location whose write is still in flight, with lane masks that differ between the two words. Both latency modes are run, one on each side of a reset, and the reset shows the posted write being lost.

// File: rtl/ddr_burst_sram_pkg.sv
package ddr_burst_sram_pkg;

    // Write-path sequencer: one state per slot of an accepted write
    typedef enum logic [2:0] {
        WS_IDLE,    // no write data expected in this slot
        WS_GAP,     // negative slot right after a write command
        WS_LO,      // positive slot: lower word sampled
        WS_HI,      // negative slot: upper word sampled, write completes
        WS_HI_GAP   // upper word of one write, gap slot of the next
    } wr_state_e;

endpackage

// File: rtl/ddr_burst_sram_wrseq.sv
module ddr_burst_sram_wrseq
    import ddr_burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    output logic cap_lo,
    output logic cap_hi
);

    wr_state_e state_q;
    wr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   state_d = wr_cmd ? WS_GAP : WS_IDLE;
            WS_GAP:    state_d = WS_LO;
            WS_LO:     state_d = wr_cmd ? WS_HI_GAP : WS_HI;
            WS_HI:     state_d = WS_IDLE;
            WS_HI_GAP: state_d = WS_LO;
            default:   state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        cap_lo = 1'b0;
        cap_hi = 1'b0;
        unique case (state_q)
            WS_LO:             cap_lo = 1'b1;
            WS_HI, WS_HI_GAP:  cap_hi = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_burst_sram_bank.sv
module ddr_burst_sram_bank #(
    parameter int ADDR_W     = 6,
    parameter int WORD_W     = 18,
    parameter int BYTE_LANES = 2
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [BYTE_LANES-1:0] lane_en,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [WORD_W-1:0]     rdata
);

    localparam int LANE_W = WORD_W / BYTE_LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    // One storage array per lane so each lane has a single writer
    for (genvar l = 0; l < BYTE_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[l]) begin
                cells[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/ddr_burst_sram_outq.sv
module ddr_burst_sram_outq #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_full,
    input  logic              load,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);

    // stage1 holds the word for two slots ahead, stage2 for three
    logic [WORD_W-1:0] st1_q, st2_q;
    logic              v1_q,  v2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q   <= '0;
            st2_q   <= '0;
            v1_q    <= 1'b0;
            v2_q    <= 1'b0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout    <= v1_q ? st1_q : '0;
            dout_oe <= v1_q;
            st1_q   <= st2_q;
            v1_q    <= v2_q;
            st2_q   <= '0;
            v2_q    <= 1'b0;
            if (load) begin
                if (lat_full) begin
                    st1_q <= word0;
                    v1_q  <= 1'b1;
                    st2_q <= word1;
                    v2_q  <= 1'b1;
                end else begin
                    dout    <= word0;
                    dout_oe <= 1'b1;
                    st1_q   <= word1;
                    v1_q    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
    parameter int ADDR_W     = 6,
    parameter int WORD_W     = 18,
    parameter int BYTE_LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slot_pos,
    input  logic                  lat_full,
    input  logic                  ld_n,
    input  logic                  rd_wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     din,
    input  logic [BYTE_LANES-1:0] bsel_n,
    output logic [WORD_W-1:0]     dout,
    output logic                  dout_oe
);

    localparam int BURST     = 2;
    localparam int LANE_W    = WORD_W / BYTE_LANES;
    localparam int LOC_W     = WORD_W * BURST;
    localparam int LOC_LANES = BYTE_LANES * BURST;

    // Command decode: only positive slots carry commands
    logic wr_cmd, rd_cmd;
    assign wr_cmd = slot_pos && !ld_n && !rd_wr;
    assign rd_cmd = slot_pos && !ld_n &&  rd_wr;

    logic cap_lo, cap_hi;

    ddr_burst_sram_wrseq u_wrseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cmd (wr_cmd),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi)
    );

    // Write staging
    logic [ADDR_W-1:0]     wa_pend, wa_act;
    logic [WORD_W-1:0]     lo_data;
    logic [BYTE_LANES-1:0] lo_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wa_pend <= '0;
            wa_act  <= '0;
            lo_data <= '0;
            lo_en   <= '0;
        end else begin
            if (wr_cmd) begin
                wa_pend <= addr;
            end
            if (cap_lo) begin
                wa_act  <= wa_pend;
                lo_data <= din;
                lo_en   <= ~bsel_n;
            end
        end
    end

    // Write completing in this slot
    logic [LOC_W-1:0]     new_data;
    logic [LOC_LANES-1:0] new_en;
    assign new_data = {din, lo_data};
    assign new_en   = {~bsel_n, lo_en};

    // Posted-write holding register
    logic                 pw_valid;
    logic [ADDR_W-1:0]    pw_addr;
    logic [LOC_W-1:0]     pw_data;
    logic [LOC_LANES-1:0] pw_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_valid <= 1'b0;
            pw_addr  <= '0;
            pw_data  <= '0;
            pw_en    <= '0;
        end else if (cap_hi) begin
            pw_valid <= 1'b1;
            pw_addr  <= wa_act;
            pw_data  <= new_data;
            pw_en    <= new_en;
        end
    end

    // Read lookup happens in the slot after the read command
    logic              rd_look;
    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_look   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_look <= rd_cmd;
            if (rd_cmd) begin
                rd_addr_q <= addr;
            end
        end
    end

    // Array: one bank per burst word; the old posted write retires
    // when a new write completes
    logic [LOC_W-1:0] arr_rd;
    logic             retire;
    assign retire = cap_hi && pw_valid;

    for (genvar w = 0; w < BURST; w++) begin : g_bank
        ddr_burst_sram_bank #(
            .ADDR_W     (ADDR_W),
            .WORD_W     (WORD_W),
            .BYTE_LANES (BYTE_LANES)
        ) u_bank (
            .clk     (clk),
            .we      (retire),
            .lane_en (pw_en[w*BYTE_LANES +: BYTE_LANES]),
            .waddr   (pw_addr),
            .wdata   (pw_data[w*WORD_W +: WORD_W]),
            .raddr   (rd_addr_q),
            .rdata   (arr_rd[w*WORD_W +: WORD_W])
        );
    end

    // Coherent view: array, then posted register, then completing write
    logic             pw_hit, new_hit;
    logic [LOC_W-1:0] view;
    assign pw_hit  = pw_valid && (pw_addr == rd_addr_q);
    assign new_hit = cap_hi && (wa_act == rd_addr_q);

    for (genvar g = 0; g < LOC_LANES; g++) begin : g_merge
        assign view[g*LANE_W +: LANE_W] =
            (new_hit && new_en[g]) ? new_data[g*LANE_W +: LANE_W] :
            (pw_hit  && pw_en[g])  ? pw_data[g*LANE_W +: LANE_W]  :
                                     arr_rd[g*LANE_W +: LANE_W];
    end

    ddr_burst_sram_outq #(
        .WORD_W (WORD_W)
    ) u_outq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_full (lat_full),
        .load     (rd_look),
        .word0    (view[WORD_W-1:0]),
        .word1    (view[LOC_W-1:WORD_W]),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/ddr_burst_sram_chk.sv
module ddr_burst_sram_chk #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_pos,
    input logic              lat_full,
    input logic              ld_n,
    input logic              rd_wr,
    input logic [WORD_W-1:0] dout,
    input logic              dout_oe,
    input logic              pw_valid
);

    // R1: first cycle out of reset has the output disabled
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout_oe);

    // R2: positive and negative slots alternate
    a_r2_slot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pos |=> !slot_pos);

    // R4: full latency delivers in slots t+3 and t+4
    a_r4_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos && !ld_n && rd_wr && lat_full) |-> ##3 dout_oe ##1 dout_oe);

    // R5: reduced latency delivers in slots t+2 and t+3
    a_r5_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos && !ld_n && rd_wr && !lat_full) |-> ##2 dout_oe ##1 dout_oe);

    // R8: disabled output reads zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    // R9: posted data never silently dropped outside reset
    a_r9_posted_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |=> pw_valid);

endmodule

bind ddr_burst_sram ddr_burst_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_pos (slot_pos),
    .lat_full (lat_full),
    .ld_n     (ld_n),
    .rd_wr    (rd_wr),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .pw_valid (pw_valid)
);

// File: tb/ddr_burst_sram_test.sv
module ddr_burst_sram_test;

    localparam int AW = 5;
    localparam int WW = 18;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic          slot_pos = 1'b1;
    logic          lat_full = 1'b1;
    logic          ld_n     = 1'b1;
    logic          rd_wr    = 1'b1;
    logic [AW-1:0] addr     = '0;
    logic [WW-1:0] din      = '0;
    logic [1:0]    bsel_n   = '0;
    logic [WW-1:0] dout;
    logic          dout_oe;

    ddr_burst_sram #(.ADDR_W(AW), .WORD_W(WW), .BYTE_LANES(2)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_pos (slot_pos),
        .lat_full (lat_full),
        .ld_n     (ld_n),
        .rd_wr    (rd_wr),
        .addr     (addr),
        .din      (din),
        .bsel_n   (bsel_n),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Schedule (by absolute cycle) and reference model (by address)
    bit            rd_at  [int];
    bit            wr_at  [int];
    logic [AW-1:0] cmd_at [int];
    logic [WW-1:0] din_at [int];
    logic [1:0]    bs_at  [int];
    logic [35:0]   mdl    [int];
    logic [WW-1:0] exp_d  [int];
    string         exp_t  [int];
    int            last_wa = -1;

    task automatic check(string req, logic [WW:0] act, logic [WW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got oe/data %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic sched_write(int c, int a, logic [WW-1:0] d0, logic [WW-1:0] d1,
                               logic [1:0] b0, logic [1:0] b1);
        logic [35:0] cur;
        cur = mdl.exists(a) ? mdl[a] : 36'd0;
        wr_at[c] = 1'b1;
        cmd_at[c] = AW'(a);
        din_at[c+2] = d0; bs_at[c+2] = b0;
        din_at[c+3] = d1; bs_at[c+3] = b1;
        for (int k = 0; k < 2; k++) begin
            if (!b0[k]) cur[k*9 +: 9]      = d0[k*9 +: 9];
            if (!b1[k]) cur[18 + k*9 +: 9] = d1[k*9 +: 9];
        end
        mdl[a] = cur;
        last_wa = a;
    endtask

    task automatic sched_read(int c, int a, string tag);
        int lat;
        lat = lat_full ? 3 : 2;
        rd_at[c] = 1'b1;
        cmd_at[c] = AW'(a);
        exp_d[c+lat]   = mdl[a][17:0];
        exp_t[c+lat]   = tag;
        exp_d[c+lat+1] = mdl[a][35:18];
        exp_t[c+lat+1] = tag;
    endtask

    task automatic drive(int c);
        logic [31:0] junk;
        junk = c * 40503 + 977;
        slot_pos = (c % 2 == 0);
        addr  = junk[AW-1:0];
        if (rd_at.exists(c)) begin
            ld_n = 1'b0; rd_wr = 1'b1; addr = cmd_at[c];
        end else if (wr_at.exists(c)) begin
            ld_n = 1'b0; rd_wr = 1'b0; addr = cmd_at[c];
        end else if (c % 2 == 1) begin
            // R2: commands in negative slots must be ignored
            ld_n = 1'b0; rd_wr = junk[3];
        end else begin
            ld_n = 1'b1; rd_wr = junk[4];
        end
        // R10: junk data and enabled lanes outside write data slots
        din    = din_at.exists(c) ? din_at[c] : junk[WW+4:5];
        bsel_n = bs_at.exists(c)  ? bs_at[c]  : 2'b00;
    endtask

    task automatic run_to(int last);
        while (cyc < last) begin
            @(negedge clk);
            if (exp_t.exists(cyc))
                check(exp_t[cyc], {dout_oe, dout}, {1'b1, exp_d[cyc]});
            else
                check("R8", {dout_oe, dout}, '0);
            drive(cyc);
        end
    endtask

    task automatic do_reset(bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        ld_n  = 1'b1;
        lat_full = mode;
        repeat (3) begin
            @(negedge clk);
            check("R1", {dout_oe, dout}, '0);
        end
        rst_n = 1'b1;
        // R1: the posted write is lost on reset
        if (last_wa >= 0) mdl.delete(last_wa);
    endtask

    function automatic int next_even(int c);
        return (c % 2 == 0) ? c + 4 : c + 5;
    endfunction

    initial begin
        int b, c;
        do_reset(1'b1);

        // ---- full latency ----
        b = next_even(cyc);
        for (int i = 0; i < 6; i++)
            sched_write(b + 2*i, i, WW'(18'h0A5A0 + i*18'h01111), WW'(18'h15A5F - i*18'h00707),
                        2'b00, 2'b00);
        b = b + 14;
        sched_read(b, 0, "R4");
        sched_read(b + 2, 5, "R9");            // still in posted register
        sched_read(b + 4, 1, "R6");
        sched_read(b + 6, 3, "R3");
        b = b + 20;
        sched_write(b, 2, 18'h3FFFF, 18'h2AAAA, 2'b10, 2'b01);   // R7: partial lanes
        sched_read(b + 2, 2, "R7");
        sched_write(b + 4, 4, 18'h12345, 18'h0BEEF, 2'b00, 2'b00);
        sched_write(b + 6, 4, 18'h3C3C3, 18'h00F0F, 2'b01, 2'b10);
        sched_read(b + 8, 4, "R9");
        sched_read(b + 10, 2, "R7");
        b = b + 24;
        sched_read(b, 3, "R10");
        sched_read(b + 2, 0, "R2");
        run_to(b + 14);

        // ---- reduced latency ----
        do_reset(1'b0);
        c = next_even(cyc);
        sched_write(c, 7, 18'h01234, 18'h3ABCD, 2'b00, 2'b00);
        sched_read(c + 2, 7, "R9");
        sched_write(c + 4, 8, 18'h2F0F0, 18'h10101, 2'b00, 2'b00);
        sched_read(c + 6, 8, "R5");
        sched_read(c + 8, 7, "R6");
        sched_read(c + 10, 2, "R6");
        sched_read(c + 12, 1, "R5");
        sched_write(c + 14, 8, 18'h00000, 18'h3FFFF, 2'b11, 2'b10);
        sched_read(c + 16, 8, "R7");
        run_to(c + 30);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, got hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule